// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer with Alternating Byte Clocks

This block is the receive framing stage of a 10-bit serial link. It takes one already retimed bit per enabled clock cycle from one of three sources: line input A, line input B, or an internal wrap stream coming from the local transmitter. It assembles the bits into 10-bit words. It watches every bit position for the positive-disparity comma, and it moves the word boundary onto a comma when it finds one. Recovered words leave on a registered bus. Two complementary byte clocks run at half the word rate, and successive words are marked by the rising edge of one clock and then the other.

Realignment never produces a short clock pulse. A byte-clock level whose boundary moves is held longer instead. When the clock phase is wrong for a comma, one non-comma word is dropped so that the comma lands on the rising edge of byte clock 1. A byte-sync enable turns off the search and everything that depends on it. A signal-detect input forces the word bus to all ones when line B is the active source and has lost its signal.

Top module: `comma_align_deser`

## Requirements
- R1: The bit source is the wrap input when `lb_en` is 1. Otherwise it is `ser_a` when `in_sel` is 0 and `ser_b` when `in_sel` is 1. Inputs that are not selected have no effect on the output.
- R2: The first bit received of a word appears on `rx_word[0]` and the last one on `rx_word[9]`.
- R3: A comma is a word whose bits 0 to 6, in arrival order, are 0,0,1,1,1,1,1 (10'h17C and 10'h07C both qualify, because bits 7 to 9 are ignored). A comma is found at any bit offset in the stream.
- R4: `byte_clk0` is always the complement of `byte_clk1`. Successive words are presented alternately on a rising edge of `byte_clk1` and then of `byte_clk0`. Out of reset, `byte_clk1`=0, `byte_clk0`=1, `rx_word`=0 and `comma_strobe`=0.
- R5: Every high and every low level of a byte clock lasts at least 10 enabled bits, including across a realignment.
- R6: With byte-sync on, no comma is lost. From the second comma onward, each comma is presented on a rising edge of `byte_clk1`, and the word that followed it on the line is presented on the next rising edge of `byte_clk0`.
- R7: With no realignment, words are framed every 10 enabled bits counted from reset. Each word is presented at the boundary that follows the one at which it completed, so the first word presented after reset is 0.
- R8: `comma_strobe` is high for one clock cycle, together with the presentation of a comma word, only while byte-sync is on and no loss of signal is flagged.
- R9: With `sync_en` low, the framing never moves and `comma_strobe` stays low.
- R10: When `lb_en`=0, `in_sel`=1 and `sig_det`=0, `rx_word` is all ones from the next clock edge onward, and `comma_strobe` stays low. When line A or the wrap source is selected, `sig_det` has no effect.
- R11: Only cycles with `bit_en` high shift a bit in or advance the framing. The byte clocks change only on such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | A new retimed bit is present this cycle |
| lb_en | input | 1 | Take bits from the internal wrap stream |
| in_sel | input | 1 | Line select when not wrapping: 0 = A, 1 = B |
| ser_a | input | 1 | Retimed bit from line A |
| ser_b | input | 1 | Retimed bit from line B |
| lb_bit | input | 1 | Retimed bit from the local transmitter wrap path |
| sync_en | input | 1 | Enable comma search, realignment and strobe |
| sig_det | input | 1 | Line B amplitude is valid (0 = lost) |
| rx_word | output | 10 | Recovered word, bit 0 received first |
| byte_clk0 | output | 1 | Half-rate byte clock, odd words |
| byte_clk1 | output | 1 | Half-rate byte clock, even words and commas |
| comma_strobe | output | 1 | One-cycle pulse with each presented comma |

## Verification
Ordered sets of two words (a comma followed by a data word) are sent after 0, 3, 7, 13 and 19 junk bits, so that the comma reaches the framing at several different offsets. Some offsets find the byte clock in the right phase and some force a dropped word. The two comma tails are alternated to show that bits 7 to 9 are ignored. Data words are asymmetric, so reversed bit order or swapped clock phases give visibly different values. The same stream is sent through line B, through the wrap path, and with bits on every second cycle only. This tells source selection and bit gating apart from framing. A misaligned stream with byte-sync off must come out on the fixed reset framing with no strobe. A loss-of-signal run checks the forcing to all ones and the return to real data.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W_DEF    = 10;
  localparam int COMMA_LEN_DEF = 7;
  // arrival order bit0..bit6 = 0,0,1,1,1,1,1
  localparam logic [COMMA_LEN_DEF-1:0] COMMA_PAT_DEF = 7'b1111100;

  typedef enum logic [1:0] {
    SRC_LINE_A = 2'd0,
    SRC_LINE_B = 2'd1,
    SRC_WRAP   = 2'd2
  } rx_src_e;
endpackage

// File: rtl/rxd_src_sel.sv
module rxd_src_sel
  import rxd_pkg::*;
(
  input  logic lb_en,
  input  logic in_sel,
  input  logic ser_a,
  input  logic ser_b,
  input  logic lb_bit,
  input  logic sig_det,
  output logic bit_o,
  output logic los_o
);
  rx_src_e src;

  always_comb begin
    if (lb_en)       src = SRC_WRAP;
    else if (in_sel) src = SRC_LINE_B;
    else             src = SRC_LINE_A;
  end

  always_comb begin
    unique case (src)
      SRC_WRAP:   bit_o = lb_bit;
      SRC_LINE_B: bit_o = ser_b;
      default:    bit_o = ser_a;
    endcase
  end

  // signal detect only monitors line B
  assign los_o = (src == SRC_LINE_B) && !sig_det;
endmodule

// File: rtl/rxd_bit_hist.sv
module rxd_bit_hist #(
  parameter int WORD_W    = 10,
  parameter int COMMA_LEN = 7,
  parameter logic [COMMA_LEN-1:0] COMMA_PAT = 7'b1111100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] older_word,
  output logic              comma_now
);
  localparam int HIST_W = 2 * WORD_W;

  logic [HIST_W-2:0]    hist_q;
  logic [HIST_W-1:0]    hist_nx;
  logic [COMMA_LEN-1:0] hit;

  // newest bit enters at the top, oldest sits at bit 0
  assign hist_nx = {bit_i, hist_q};

  always_ff @(posedge clk) begin
    if (rst)         hist_q <= '0;
    else if (bit_en) hist_q <= hist_nx[HIST_W-1:1];
  end

  // word that completed one word time before the newest one
  assign older_word = hist_nx[WORD_W-1:0];

  // sliding comparison against the newest full word, start of word at WORD_W
  for (genvar i = 0; i < COMMA_LEN; i++) begin : g_cmp
    assign hit[i] = (hist_nx[WORD_W+i] == COMMA_PAT[i]);
  end

  assign comma_now = bit_en && (&hit);
endmodule

// File: rtl/rxd_frame_ctl.sv
module rxd_frame_ctl #(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic comma_now,
  input  logic sync_en,
  output logic load_o,
  output logic clk1_o,
  output logic clk0_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             clk1_q, clk0_q;
  logic             at_end, boundary, realign, skip;

  assign at_end   = (cnt_q == LAST);
  assign boundary = bit_en && at_end;
  // comma ends off the current boundary: restart the word count here
  assign realign  = comma_now && sync_en && !at_end;
  // comma ends on a boundary while byte clock 1 is low: hold both clocks one
  // more word so that the comma reaches a rising edge of byte clock 1
  assign skip     = boundary && comma_now && sync_en && !clk1_q;
  assign load_o   = boundary && !skip;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (bit_en) begin
      if (realign || at_end) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk1_q <= 1'b0;
      clk0_q <= 1'b1;
    end else if (load_o) begin
      clk1_q <= !clk1_q;
      clk0_q <= clk1_q;
    end
  end

  assign clk1_o = clk1_q;
  assign clk0_o = clk0_q;
endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser
  import rxd_pkg::*;
#(
  parameter int WORD_W    = WORD_W_DEF,
  parameter int COMMA_LEN = COMMA_LEN_DEF,
  parameter logic [COMMA_LEN-1:0] COMMA_PAT = COMMA_PAT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              lb_en,
  input  logic              in_sel,
  input  logic              ser_a,
  input  logic              ser_b,
  input  logic              lb_bit,
  input  logic              sync_en,
  input  logic              sig_det,
  output logic [WORD_W-1:0] rx_word,
  output logic              byte_clk0,
  output logic              byte_clk1,
  output logic              comma_strobe
);
  logic              bit_s, los;
  logic [WORD_W-1:0] older_word;
  logic              comma_now, load;

  rxd_src_sel u_sel (
    .lb_en   (lb_en),
    .in_sel  (in_sel),
    .ser_a   (ser_a),
    .ser_b   (ser_b),
    .lb_bit  (lb_bit),
    .sig_det (sig_det),
    .bit_o   (bit_s),
    .los_o   (los)
  );

  rxd_bit_hist #(
    .WORD_W    (WORD_W),
    .COMMA_LEN (COMMA_LEN),
    .COMMA_PAT (COMMA_PAT)
  ) u_hist (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_i      (bit_s),
    .older_word (older_word),
    .comma_now  (comma_now)
  );

  rxd_frame_ctl #(
    .WORD_W (WORD_W)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .comma_now (comma_now),
    .sync_en   (sync_en),
    .load_o    (load),
    .clk1_o    (byte_clk1),
    .clk0_o    (byte_clk0)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word      <= '0;
      comma_strobe <= 1'b0;
    end else begin
      if (los)       rx_word <= '1;
      else if (load) rx_word <= older_word;
      comma_strobe <= load && sync_en && !los &&
                      (older_word[COMMA_LEN-1:0] == COMMA_PAT);
    end
  end
endmodule

// File: rtl/comma_align_deser_chk.sv
module comma_align_deser_chk #(
  parameter int WORD_W    = 10,
  parameter int COMMA_LEN = 7,
  parameter logic [COMMA_LEN-1:0] COMMA_PAT = 7'b1111100
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              lb_en,
  input logic              in_sel,
  input logic              sync_en,
  input logic              sig_det,
  input logic [WORD_W-1:0] rx_word,
  input logic              byte_clk0,
  input logic              byte_clk1,
  input logic              comma_strobe
);
  logic       clk1_seen;
  logic [7:0] lvl_bits;

  // enabled bits since the last byte clock change, saturating
  always_ff @(posedge clk) begin
    if (rst) begin
      clk1_seen <= 1'b0;
      lvl_bits  <= '0;
    end else begin
      clk1_seen <= byte_clk1;
      if (byte_clk1 != clk1_seen) lvl_bits <= {7'd0, bit_en};
      else if (bit_en && lvl_bits != 8'hFF) lvl_bits <= lvl_bits + 8'd1;
    end
  end

  p_clk_compl_r4: assert property (@(posedge clk) disable iff (rst)
    byte_clk0 != byte_clk1);

  p_min_level_r5: assert property (@(posedge clk) disable iff (rst)
    (byte_clk1 != clk1_seen) |-> (lvl_bits >= 8'(WORD_W)));

  p_strobe_comma_r8: assert property (@(posedge clk) disable iff (rst)
    comma_strobe |-> (rx_word[COMMA_LEN-1:0] == COMMA_PAT) && $past(sync_en));

  p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !sync_en |=> !comma_strobe);

  p_los_ones_r10: assert property (@(posedge clk) disable iff (rst)
    (in_sel && !lb_en && !sig_det) |=> (rx_word == '1) && !comma_strobe);

  p_clk_gated_r11: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(byte_clk1));
endmodule

bind comma_align_deser comma_align_deser_chk #(
  .WORD_W    (WORD_W),
  .COMMA_LEN (COMMA_LEN),
  .COMMA_PAT (COMMA_PAT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bit_en       (bit_en),
  .lb_en        (lb_en),
  .in_sel       (in_sel),
  .sync_en      (sync_en),
  .sig_det      (sig_det),
  .rx_word      (rx_word),
  .byte_clk0    (byte_clk0),
  .byte_clk1    (byte_clk1),
  .comma_strobe (comma_strobe)
);

// File: tb/sim_comma_align_deser.sv
module sim_comma_align_deser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, lb_en = 1'b0, in_sel = 1'b0;
  logic ser_a = 1'b1, ser_b = 1'b1, lb_bit = 1'b1;
  logic sync_en = 1'b1, sig_det = 1'b1;
  logic [9:0] rx_word;
  logic byte_clk0, byte_clk1, comma_strobe;

  localparam logic [9:0] COMMA_A = 10'h17C;
  localparam logic [9:0] COMMA_B = 10'h07C;

  comma_align_deser u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .lb_en(lb_en), .in_sel(in_sel),
    .ser_a(ser_a), .ser_b(ser_b), .lb_bit(lb_bit), .sync_en(sync_en),
    .sig_det(sig_det), .rx_word(rx_word), .byte_clk0(byte_clk0),
    .byte_clk1(byte_clk1), .comma_strobe(comma_strobe)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;

  // event log filled at falling edges
  logic [9:0] ev_word [0:255];
  bit         ev_on1  [0:255];
  bit         ev_str  [0:255];
  int n_ev, strobe_cnt, min_w, run_len;
  bit have_tgl;
  logic p1, p0;

  logic sbits [0:2047];
  int   s_len;

  always @(negedge clk) begin
    if (rst) begin
      n_ev = 0; strobe_cnt = 0; min_w = 1000; run_len = 0; have_tgl = 0;
      p1 = byte_clk1; p0 = byte_clk0;
    end else begin
      if (comma_strobe) strobe_cnt++;
      if (byte_clk1 && !p1 && n_ev < 256) begin
        ev_word[n_ev] = rx_word; ev_on1[n_ev] = 1'b1; ev_str[n_ev] = comma_strobe; n_ev++;
      end else if (byte_clk0 && !p0 && n_ev < 256) begin
        ev_word[n_ev] = rx_word; ev_on1[n_ev] = 1'b0; ev_str[n_ev] = comma_strobe; n_ev++;
      end
      if (byte_clk1 != p1) begin
        if (have_tgl && run_len < min_w) min_w = run_len;
        have_tgl = 1'b1; run_len = 1;
      end else run_len++;
      p1 = byte_clk1; p0 = byte_clk0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] dat(input int j);
    case (j % 5)
      0: return 10'h155;
      1: return 10'h2AA;
      2: return 10'h0CC;
      3: return 10'h333;
      default: return 10'h199;
    endcase
  endfunction

  function automatic logic [9:0] cma(input int j);
    return (j % 2 == 0) ? COMMA_A : COMMA_B;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; s_len = 0;
  endtask

  task automatic push_bit(input logic b, input int src, input bit sparse);
    @(negedge clk);
    case (src)
      0: ser_a = b;
      1: ser_b = b;
      default: lb_bit = b;
    endcase
    bit_en = 1'b1;
    sbits[s_len] = b; s_len++;
    if (sparse) begin
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic push_word(input logic [9:0] w, input int src, input bit sparse);
    for (int i = 0; i < 10; i++) push_bit(w[i], src, sparse);
  endtask

  task automatic finish_stream();
    @(negedge clk);
    bit_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // ordered sets after k junk bits, checked for alignment and contents
  task automatic run_aligned(input int src, input int k, input int m_sets,
                             input bit sparse, input logic sd, input string tag);
    int c0, c1, nc, errs, idx;
    do_reset();
    lb_en = (src == 2); in_sel = (src == 1); sig_det = sd; sync_en = 1'b1;
    ser_a = 1'b1; ser_b = 1'b1; lb_bit = 1'b1;
    for (int j = 0; j < k; j++) push_bit(j % 2 == 0, src, sparse);
    for (int m = 0; m < m_sets; m++) begin
      push_word(cma(m), src, sparse);
      push_word(dat(m), src, sparse);
    end
    for (int j = 0; j < 30; j++) push_bit(j % 2 == 0, src, sparse);
    finish_stream();
    c0 = -1; c1 = -1; nc = 0;
    for (int e = 0; e < n_ev; e++) begin
      if (ev_word[e][6:0] == 7'b1111100) begin
        if (c0 < 0) c0 = e; else if (c1 < 0) c1 = e;
        nc++;
      end
    end
    $display("scenario %s: events=%0d", tag, n_ev);
    // R3: every comma found whatever the offset, both tails accepted
    chk(nc == m_sets, "R3 comma count", nc, m_sets);
    // R1 R2 R6: from the second comma, comma on clk1 then its data on clk0
    errs = 0;
    if (c1 < 0) errs = 1;
    else for (int j = 1; j < m_sets; j++) begin
      idx = c1 + 2 * (j - 1);
      if (idx + 1 >= n_ev) errs++;
      else begin
        if (!ev_on1[idx] || ev_word[idx] != cma(j) || !ev_str[idx]) errs++;
        if (ev_on1[idx+1] || ev_word[idx+1] != dat(j)) errs++;
      end
    end
    chk(errs == 0, "R1 R2 R6 aligned sequence", errs, 0);
    // R8: one strobe per presented comma
    chk(strobe_cnt == m_sets, "R8 strobe count", strobe_cnt, m_sets);
    // R5 R11: no level shorter than one word of enabled bits
    chk(min_w >= (sparse ? 20 : 10), "R5 R11 min level", min_w, sparse ? 20 : 10);
  endtask

  task automatic run_nosync();
    int errs;
    logic [9:0] w;
    do_reset();
    lb_en = 1'b0; in_sel = 1'b0; sig_det = 1'b1; sync_en = 1'b0;
    ser_b = 1'b1; lb_bit = 1'b1;
    for (int j = 0; j < 3; j++) push_bit(j % 2 == 0, 0, 1'b0);
    for (int m = 0; m < 6; m++) begin
      push_word(cma(m), 0, 1'b0);
      push_word(dat(m), 0, 1'b0);
    end
    for (int j = 0; j < 30; j++) push_bit(j % 2 == 0, 0, 1'b0);
    finish_stream();
    // R9: no strobe with byte-sync off
    chk(strobe_cnt == 0, "R9 strobe off", strobe_cnt, 0);
    // R7: fixed framing from reset, one word of delay, first word zero
    errs = 0;
    if (n_ev < 10 || ev_word[0] != 10'h000) errs++;
    for (int n = 1; n < n_ev; n++) begin
      if (10 * n <= s_len) begin
        for (int b = 0; b < 10; b++) w[b] = sbits[10 * (n - 1) + b];
        if (ev_word[n] != w) errs++;
      end
    end
    chk(errs == 0, "R7 R9 fixed framing", errs, 0);
    // R4: alternating presentation starting on clk1
    errs = 0;
    for (int n = 0; n < n_ev; n++) if (ev_on1[n] != (n % 2 == 0)) errs++;
    chk(errs == 0, "R4 alternation", errs, 0);
    sync_en = 1'b1;
  endtask

  task automatic run_los();
    do_reset();
    lb_en = 1'b0; in_sel = 1'b1; sig_det = 1'b0; sync_en = 1'b1;
    ser_a = 1'b1; lb_bit = 1'b1;
    for (int j = 0; j < 25; j++) push_bit(j % 2 == 0, 1, 1'b0);
    chk(rx_word == 10'h3FF, "R10 forced ones", rx_word, 10'h3FF);
    push_word(COMMA_A, 1, 1'b0); push_word(dat(0), 1, 1'b0);
    push_word(COMMA_B, 1, 1'b0); push_word(dat(1), 1, 1'b0);
    push_word(10'h155, 1, 1'b0);
    finish_stream();
    chk(rx_word == 10'h3FF, "R10 forced ones with commas", rx_word, 10'h3FF);
    chk(strobe_cnt == 0, "R10 strobe suppressed", strobe_cnt, 0);
    sig_det = 1'b1;
    for (int j = 0; j < 40; j++) push_bit(j % 2 == 0, 1, 1'b0);
    finish_stream();
    chk(rx_word == 10'h155, "R10 data restored", rx_word, 10'h155);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk(rx_word == 10'h000, "R4 reset word", rx_word, 0);
    chk(byte_clk1 == 1'b0 && byte_clk0 == 1'b1, "R4 reset clocks",
        {byte_clk1, byte_clk0}, 2'b01);
    chk(comma_strobe == 1'b0, "R4 reset strobe", comma_strobe, 0);

    run_aligned(0, 0,  8, 1'b0, 1'b1, "lineA_off0");
    run_aligned(0, 7,  8, 1'b0, 1'b1, "lineA_off7");
    run_aligned(1, 13, 8, 1'b0, 1'b1, "lineB_off13");
    run_aligned(2, 3,  8, 1'b0, 1'b0, "wrap_off3");
    run_aligned(0, 19, 6, 1'b1, 1'b0, "lineA_sparse_off19");
    run_nosync();
    run_los();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule